// File: doc/BRIEF.md
# Host Register Space Decoder with Reset Access Lock

This block sits between a host bus and the register-mapped part of a display-type controller. Each host access with the chip select low and the memory/register select low lands on one of three targets, picked by the address. The top address bit opens a 1 MB port into the pixel engine. One middle address bit opens a 4 KB auxiliary register window, but only when a configuration strap sampled at reset allows it. All other addresses reach a 512-byte main register space that the block implements itself.

Out of reset the block is locked. Only main register 000h can be read, and it holds a fixed identification value. Only main register 001h can be read and written. Bit 7 of register 001h is the lock bit. A host write that clears it opens every register and both windows. Address bits that the selected window does not use are ignored, so registers alias across their space.

The host sees the selects, the offsets and the read data combinationally in the access cycle. Writes to main registers take effect at the clock edge that ends that cycle.

Top module: `rsd_host_decoder`

## Requirements
- R1: No target select is asserted and read data is 00h unless host_cs_n=0, host_mr_n=0 and host_rd or host_wr is 1.
- R2: With address bit 20 = 1, pix_sel is 1, pix_off carries address bits 19..0, and a read returns pix_rdata.
- R3: With address bit 20 = 0 and bit 12 = 0, the access goes to main register index address[8:0]. Bits 9..11 and 13..19 are ignored, so for example 0E03h and 4203h both reach register 003h.
- R4: With the strap latched as 1, address bit 20 = 0 and bit 12 = 1, aux_sel is 1, aux_off carries address bits 11..0, and a read returns aux_rdata.
- R5: With the strap latched as 0, address bit 12 is treated as 0. aux_sel never asserts, and 1004h reaches main register 004h.
- R6: The strap is sampled at the first rising clock edge after reset release and is held until the next reset. Later changes on cfg_aux_en have no effect.
- R7: The lock bit is bit 7 of main register 001h. Register 001h resets to 80h, so the block starts locked.
- R8: While locked, every access other than one to main register 000h or 001h is blocked. A blocked access reads 00h, discards its write and asserts no select.
- R9: A write to register 001h takes all 8 bits. If bit 7 is written as 0, the lock is released from the next cycle. Writing bit 7 back to 1 locks again.
- R10: Main register 000h always reads ID_VALUE (default A5h). Writes to it are ignored.
- R11: Only main indices below NUM_REGS (default 16) are implemented. Reads above that return 00h and writes there have no effect. Registers 002h and up reset to 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_aux_en | input | 1 | Configuration strap enabling the auxiliary window |
| host_cs_n | input | 1 | Chip select, active low |
| host_mr_n | input | 1 | Memory/register select; 0 selects register space |
| host_addr | input | 21 | Host byte address |
| host_rd | input | 1 | Read strobe |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data |
| pix_sel | output | 1 | Pixel-engine data port selected |
| pix_off | output | 20 | Offset into the pixel-engine window |
| pix_rdata | input | 8 | Read data returned by the pixel engine |
| aux_sel | output | 1 | Auxiliary window selected |
| aux_off | output | 12 | Offset into the auxiliary window |
| aux_rdata | input | 8 | Read data returned by the auxiliary logic |

## Verification
The assertions check on every cycle that a locked block never selects either window. They also check that aux_sel stays low when the strap was latched as 0, that an idle bus produces no select and zero read data, that the latched strap never moves after its sampling edge, and that a write to register 001h lands in the lock bit. Other behaviour needs a sequence of accesses and only the bench's scenarios can show it. This covers aliasing of main registers, the discarding of writes made while locked (observed by reading back after the unlock), the read-only identification byte, unimplemented indices, and strap changes after the sampling edge.

// File: rtl/rsd_pkg.sv
package rsd_pkg;
    typedef enum logic [1:0] {
        TGT_MAIN = 2'd0,
        TGT_PIX  = 2'd1,
        TGT_AUX  = 2'd2
    } rsd_target_e;

    typedef struct packed {
        logic armed;
        logic aux_en;
    } rsd_strap_t;
endpackage

// File: rtl/rsd_window_decode.sv
module rsd_window_decode
    import rsd_pkg::*;
#(
    parameter int ADDR_W     = 21,
    parameter int AUX_OFF_W  = 12,
    parameter int MAIN_IDX_W = 9
) (
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  aux_en,
    output rsd_target_e           target,
    output logic [ADDR_W-2:0]     pix_off,
    output logic [AUX_OFF_W-1:0]  aux_off,
    output logic [MAIN_IDX_W-1:0] main_idx
);
    localparam int PIX_BIT = ADDR_W - 1;
    localparam int AUX_BIT = AUX_OFF_W;

    always_comb begin
        pix_off  = addr[PIX_BIT-1:0];
        aux_off  = addr[AUX_OFF_W-1:0];
        main_idx = addr[MAIN_IDX_W-1:0];
        if (addr[PIX_BIT]) begin
            target = TGT_PIX;
        end else if (aux_en && addr[AUX_BIT]) begin
            target = TGT_AUX;
        end else begin
            target = TGT_MAIN;
        end
    end
endmodule

// File: rtl/rsd_access_gate.sv
module rsd_access_gate
    import rsd_pkg::*;
#(
    parameter int MAIN_IDX_W = 9
) (
    input  logic                  locked,
    input  rsd_target_e           target,
    input  logic [MAIN_IDX_W-1:0] main_idx,
    output logic                  allowed
);
    localparam logic [MAIN_IDX_W-1:0] LAST_OPEN = MAIN_IDX_W'(1);

    always_comb begin
        allowed = !locked || (target == TGT_MAIN && main_idx <= LAST_OPEN);
    end
endmodule

// File: rtl/rsd_main_regs.sv
module rsd_main_regs #(
    parameter int          MAIN_IDX_W = 9,
    parameter int          NUM_REGS   = 16,
    parameter logic [7:0]  ID_VALUE   = 8'hA5,
    parameter logic [7:0]  CTRL_RESET = 8'h80
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [MAIN_IDX_W-1:0] idx,
    input  logic [7:0]            wdata,
    output logic [7:0]            rd_data,
    output logic                  locked
);
    localparam int                    IW       = $clog2(NUM_REGS);
    localparam logic [MAIN_IDX_W-1:0] IDX_LIM  = MAIN_IDX_W'(NUM_REGS);
    localparam logic [MAIN_IDX_W-1:0] IDX_CTRL = MAIN_IDX_W'(1);
    localparam int                    LOCK_BIT = 7;

    logic [NUM_REGS-1:0][7:0] regs_d, regs_q;
    logic                     in_range;

    always_comb begin
        in_range = idx < IDX_LIM;
        regs_d   = regs_q;
        if (wr_en && in_range && idx != '0) begin
            regs_d[idx[IW-1:0]] = wdata;
        end
        regs_d[0] = 8'h00;
        if (!in_range) begin
            rd_data = 8'h00;
        end else if (idx == '0) begin
            rd_data = ID_VALUE;
        end else begin
            rd_data = regs_q[idx[IW-1:0]];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q    <= '0;
            regs_q[1] <= CTRL_RESET;
        end else begin
            regs_q    <= regs_d;
        end
    end

    assign locked = regs_q[1][LOCK_BIT];

    p_lock_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == IDX_CTRL) |=> (locked == $past(wdata[LOCK_BIT])));

    p_discard_unimpl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !in_range) |=> $stable(regs_q));
endmodule

// File: rtl/rsd_host_decoder.sv
module rsd_host_decoder
    import rsd_pkg::*;
#(
    parameter int         ADDR_W     = 21,
    parameter int         AUX_OFF_W  = 12,
    parameter int         MAIN_IDX_W = 9,
    parameter int         NUM_REGS   = 16,
    parameter logic [7:0] ID_VALUE   = 8'hA5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_aux_en,
    input  logic                 host_cs_n,
    input  logic                 host_mr_n,
    input  logic [ADDR_W-1:0]    host_addr,
    input  logic                 host_rd,
    input  logic                 host_wr,
    input  logic [7:0]           host_wdata,
    output logic [7:0]           host_rdata,
    output logic                 pix_sel,
    output logic [ADDR_W-2:0]    pix_off,
    input  logic [7:0]           pix_rdata,
    output logic                 aux_sel,
    output logic [AUX_OFF_W-1:0] aux_off,
    input  logic [7:0]           aux_rdata
);
    rsd_strap_t              strap_d, strap_q;
    rsd_target_e             target;
    logic [MAIN_IDX_W-1:0]   main_idx;
    logic                    locked, allowed, active, granted;
    logic                    main_wr;
    logic [7:0]              main_rdata;

    always_comb begin
        strap_d = strap_q;
        if (strap_q.armed) begin
            strap_d.aux_en = cfg_aux_en;
            strap_d.armed  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strap_q <= '{armed: 1'b1, aux_en: 1'b0};
        end else begin
            strap_q <= strap_d;
        end
    end

    rsd_window_decode #(
        .ADDR_W(ADDR_W), .AUX_OFF_W(AUX_OFF_W), .MAIN_IDX_W(MAIN_IDX_W)
    ) u_dec (
        .addr(host_addr), .aux_en(strap_q.aux_en), .target(target),
        .pix_off(pix_off), .aux_off(aux_off), .main_idx(main_idx)
    );

    rsd_access_gate #(.MAIN_IDX_W(MAIN_IDX_W)) u_gate (
        .locked(locked), .target(target), .main_idx(main_idx), .allowed(allowed)
    );

    rsd_main_regs #(
        .MAIN_IDX_W(MAIN_IDX_W), .NUM_REGS(NUM_REGS), .ID_VALUE(ID_VALUE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(main_wr), .idx(main_idx),
        .wdata(host_wdata), .rd_data(main_rdata), .locked(locked)
    );

    always_comb begin
        active     = !host_cs_n && !host_mr_n && (host_rd || host_wr);
        granted    = active && allowed;
        pix_sel    = granted && target == TGT_PIX;
        aux_sel    = granted && target == TGT_AUX;
        main_wr    = granted && host_wr && target == TGT_MAIN;
        host_rdata = 8'h00;
        if (granted && host_rd) begin
            unique case (target)
                TGT_PIX: host_rdata = pix_rdata;
                TGT_AUX: host_rdata = aux_rdata;
                default: host_rdata = main_rdata;
            endcase
        end
    end

    p_lock_blocks_windows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (!pix_sel && !aux_sel));

    p_aux_absent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !strap_q.aux_en |-> !aux_sel);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cs_n || host_mr_n) |-> (!pix_sel && !aux_sel && host_rdata == 8'h00));

    p_strap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !strap_q.armed |=> $stable(strap_q.aux_en));
endmodule

// File: tb/sim_rsd_host_decoder.sv
module sim_rsd_host_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_aux_en = 1'b0;
    logic        host_cs_n = 1'b1;
    logic        host_mr_n = 1'b1;
    logic [20:0] host_addr = '0;
    logic        host_rd = 1'b0;
    logic        host_wr = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        pix_sel;
    logic [19:0] pix_off;
    logic [7:0]  pix_rdata = 8'h3C;
    logic        aux_sel;
    logic [11:0] aux_off;
    logic [7:0]  aux_rdata = 8'hD2;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    rsd_host_decoder u0 (
        .clk(clk), .rst_n(rst_n), .cfg_aux_en(cfg_aux_en),
        .host_cs_n(host_cs_n), .host_mr_n(host_mr_n), .host_addr(host_addr),
        .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .pix_sel(pix_sel), .pix_off(pix_off),
        .pix_rdata(pix_rdata), .aux_sel(aux_sel), .aux_off(aux_off),
        .aux_rdata(aux_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic strap);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_aux_en = strap;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
    endtask

    task automatic do_write(input logic [20:0] a, input logic [7:0] d);
        @(negedge clk);
        host_cs_n = 1'b0; host_mr_n = 1'b0; host_addr = a;
        host_wdata = d; host_wr = 1'b1;
        @(posedge clk);
        #1;
        host_cs_n = 1'b1; host_mr_n = 1'b1; host_wr = 1'b0;
    endtask

    task automatic do_read(input logic [20:0] a, output logic [7:0] d,
                           output logic ps, output logic as,
                           output logic [19:0] po, output logic [11:0] ao);
        @(negedge clk);
        host_cs_n = 1'b0; host_mr_n = 1'b0; host_addr = a; host_rd = 1'b1;
        #5;
        d = host_rdata; ps = pix_sel; as = aux_sel; po = pix_off; ao = aux_off;
        host_cs_n = 1'b1; host_mr_n = 1'b1; host_rd = 1'b0;
    endtask

    logic [7:0]  rd;
    logic        ps, as;
    logic [19:0] po;
    logic [11:0] ao;

    task automatic t_reset_state();
        do_reset(1'b1);
        repeat (2) @(negedge clk);
        cfg_aux_en = 1'b0;
        do_read(21'h001, rd, ps, as, po, ao); check("R7 ctrl reset", rd, 8'h80);
        do_read(21'h000, rd, ps, as, po, ao); check("R10 id value", rd, 8'hA5);
    endtask

    task automatic t_idle();
        @(negedge clk);
        host_cs_n = 1'b1; host_mr_n = 1'b0; host_addr = 21'h001; host_rd = 1'b1;
        #5; check("R1 cs high rdata", host_rdata, 8'h00);
        host_cs_n = 1'b0; host_mr_n = 1'b1; host_addr = 21'h100000;
        #2; check("R1 mr high sel", {pix_sel, aux_sel}, 2'b00);
        host_cs_n = 1'b1; host_mr_n = 1'b1; host_rd = 1'b0;
    endtask

    task automatic t_locked();
        do_write(21'h002, 8'h55);
        do_read(21'h002, rd, ps, as, po, ao); check("R8 locked main read", rd, 8'h00);
        do_read(21'h100000, rd, ps, as, po, ao);
        check("R8 locked pix sel", ps, 1'b0); check("R8 locked pix data", rd, 8'h00);
        do_read(21'h001000, rd, ps, as, po, ao); check("R8 locked aux sel", as, 1'b0);
    endtask

    task automatic t_unlock();
        do_write(21'h001, 8'h00);
        do_read(21'h001, rd, ps, as, po, ao); check("R9 ctrl cleared", rd, 8'h00);
        do_read(21'h002, rd, ps, as, po, ao); check("R8 locked write discarded", rd, 8'h00);
    endtask

    task automatic t_main_alias();
        do_write(21'h003, 8'hC3);
        do_read(21'h003, rd, ps, as, po, ao); check("R3 main rw", rd, 8'hC3);
        do_read(21'h000E03, rd, ps, as, po, ao); check("R3 alias bits 9-11", rd, 8'hC3);
        do_read(21'h004203, rd, ps, as, po, ao); check("R3 alias bit 14", rd, 8'hC3);
    endtask

    task automatic t_pix();
        do_read(21'h1ABCDE, rd, ps, as, po, ao);
        check("R2 pix sel", {ps, as}, 2'b10);
        check("R2 pix off", po, 20'hABCDE);
        check("R2 pix data", rd, 8'h3C);
    endtask

    task automatic t_aux();
        do_read(21'h001234, rd, ps, as, po, ao);
        check("R4 aux sel", {ps, as}, 2'b01);
        check("R4 aux off", ao, 12'h234);
        check("R4 aux data", rd, 8'hD2);
        check("R6 strap held after change", as, 1'b1);
    endtask

    task automatic t_id_ro();
        do_write(21'h000, 8'hFF);
        do_read(21'h000, rd, ps, as, po, ao); check("R10 id write ignored", rd, 8'hA5);
    endtask

    task automatic t_unimpl();
        do_write(21'h1F0, 8'h77);
        do_read(21'h1F0, rd, ps, as, po, ao); check("R11 high index reads zero", rd, 8'h00);
        do_read(21'h010, rd, ps, as, po, ao); check("R11 first unimpl zero", rd, 8'h00);
        do_read(21'h00F, rd, ps, as, po, ao); check("R11 last impl reset", rd, 8'h00);
    endtask

    task automatic t_relock();
        do_write(21'h001, 8'h80);
        do_read(21'h003, rd, ps, as, po, ao); check("R9 relock blocks", rd, 8'h00);
        do_read(21'h001, rd, ps, as, po, ao); check("R7 lock bit visible", rd, 8'h80);
    endtask

    task automatic t_strap_off();
        do_reset(1'b0);
        repeat (2) @(negedge clk);
        cfg_aux_en = 1'b1;
        do_read(21'h001001, rd, ps, as, po, ao); check("R5 aliased ctrl while locked", rd, 8'h80);
        do_write(21'h001001, 8'h00);
        do_write(21'h004, 8'h9A);
        do_read(21'h001004, rd, ps, as, po, ao);
        check("R5 no aux sel", as, 1'b0);
        check("R5 folds to main", rd, 8'h9A);
        check("R6 late strap ignored", as, 1'b0);
    endtask

    initial begin
        t_reset_state();
        t_idle();
        t_locked();
        t_unlock();
        t_main_alias();
        t_pix();
        t_aux();
        t_id_ro();
        t_unimpl();
        t_relock();
        t_strap_off();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule